// File: doc/BRIEF.md
# Shared-Oscillator Multichannel Phase Pre-Modulator

This block produces complex sinusoid samples for a comb of 128 channels from a single pipelined numerically controlled oscillator. Every channel owns two phase slots, a carrier slot and a nuller slot. That gives 256 slots, and the block visits them in turn so that one adder chain and one sine/cosine table serve them all. Each slot keeps a 32-bit phase in a small memory. On every visit the stored phase is advanced by the slot's increment and written back. A static per-slot offset is then added on the way to the table, and that offset never enters the stored phase.

A single pulse on the scan input starts one sweep. The sweep issues one slot per clock. Within each channel the carrier slot comes before the nuller slot, and channels run in ascending order. Each result leaves the block 13 clocks after its slot was issued, together with its channel number and a carrier/nuller marker.

Increments and offsets are loaded through a plain write port. A write lands in a shadow copy, and that copy is transferred to the working tables when the next sweep is accepted. A scan pulse that arrives while a sweep is running is dropped and sets a sticky overrun flag. The exception is a pulse in the sweep's final issue cycle: that pulse chains a new sweep with no gap.

Top module: `dds_premod`

## Requirements
- R1: An accepted scan pulse issues 256 slots on consecutive clocks, exactly once each. A slot is addressed as {channel, nuller bit}, where nuller bit 0 marks the carrier. Within each channel the carrier is issued before the nuller, and channels are issued in ascending order from 0.
- R2: Each slot keeps a 32-bit phase that is 0 after reset. On every visit the phase is advanced by the slot's increment modulo 2^32, and the advanced value is written back for the next sweep.
- R3: The slot's offset is added to the advanced phase only to form the table address. The offset is never accumulated into the stored phase.
- R4: Let p be the top 10 bits of (advanced phase + offset). outQ is round(32767*sin(2*pi*p/1024)) and outI is the same function evaluated at (p+256) mod 1024. Both are 16-bit signed.
- R5: The result for slot k of a sweep is presented with outValid high exactly 13 clocks after the accepting edge plus k. outChan and outNuller carry that slot's channel and nuller bit in the same cycle.
- R6: A write with cfgWe high stores cfgData into the shadow increment (cfgSel=0) or the shadow offset (cfgSel=1) of slot cfgAddr. The shadow tables are copied to the working tables on the edge that accepts a scan pulse, so a write made during a sweep only affects later sweeps.
- R7: A scan pulse sampled while a sweep is issuing, other than in its last issue cycle, produces no extra results and sets outOverrun. outOverrun stays high until reset.
- R8: A scan pulse sampled in the last issue cycle of a sweep starts the next sweep on the following clock with no gap in outValid, and it does not set outOverrun.
- R9: After reset, outValid and outOverrun are low, and all stored phases, increments and offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanStrobe | input | 1 | Pulse that requests one sweep |
| cfgWe | input | 1 | Shadow table write enable |
| cfgSel | input | 1 | 0 selects the increment, 1 selects the offset |
| cfgAddr | input | 8 | Slot address {channel, nuller bit} |
| cfgData | input | 32 | Value to write |
| outValid | output | 1 | Result beat present |
| outI | output | 16 | Cosine sample, signed |
| outQ | output | 16 | Sine sample, signed |
| outChan | output | 7 | Channel of the beat |
| outNuller | output | 1 | 1 for the nuller slot, 0 for the carrier slot |
| outOverrun | output | 1 | Sticky flag for an ignored scan pulse |

## Verification
Two events can fall in the same cycle: a scan pulse and the issue of a sweep's final slot. In that case the pulse must chain a new sweep and must not count as an overrun. One cycle earlier, the same pulse must be dropped and flagged. The bench holds scan pulses at both positions. The scoreboard's per-beat cycle stamps then show whether the chained sweep follows with no gap, and whether the dropped pulse added any stray beats. The overrun output is read before and after each case. A table write made in the middle of a sweep is judged by the model, which applies it only from the following sweep.

// File: rtl/dds_premod_pkg.sv
package dds_premod_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic issue;  // a slot is issued this cycle
    logic load;   // scan accepted: copy shadow tables to working tables
  } ctrl_t;

endpackage

// File: rtl/dds_premod_ctrl.sv
module dds_premod_ctrl
  import dds_premod_pkg::*;
#(
  parameter int NUM_SLOTS = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         scanStrobe,
  output ctrl_t                        ctrlS,
  output logic [$clog2(NUM_SLOTS)-1:0] issueSlot,
  output logic                         overrun
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic              busy;
  logic [SLOT_W-1:0] slotCnt;
  logic              lastSlot;
  logic              accept;

  assign lastSlot = busy && (slotCnt == SLOT_W'(NUM_SLOTS - 1));
  // a pulse in the final issue cycle chains the next sweep
  assign accept   = scanStrobe && (!busy || lastSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slotCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      slotCnt <= '0;
    end else if (busy) begin
      if (lastSlot) busy <= 1'b0;
      else          slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               overrun <= 1'b0;
    else if (scanStrobe && busy && !lastSlot) overrun <= 1'b1;
  end

  always_comb begin
    ctrlS.issue = busy;
    ctrlS.load  = accept;
    issueSlot   = slotCnt;
  end

endmodule

// File: rtl/dds_premod_lut.sv
module dds_premod_lut #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] sinQ,
  output logic signed [DW-1:0] cosQ
);

  localparam int DEPTH   = 1 << AW;
  localparam int QUARTER = DEPTH / 4;

  function automatic logic signed [DW-1:0] sinEntry(input int idx);
    real ang;
    real v;
    ang = 6.283185307179586 * idx / (2.0 ** AW);
    v   = ((2.0 ** (DW - 1)) - 1.0) * $sin(ang);
    if (v >= 0.0) return DW'($rtoi(v + 0.5));
    else          return DW'($rtoi(v - 0.5));
  endfunction

  logic signed [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam logic signed [DW-1:0] ENT = sinEntry(g);
    assign tbl[g] = ENT;
  end

  logic [AW-1:0] cosAddr;
  assign cosAddr = addr + AW'(QUARTER);

  always_ff @(posedge clk) begin
    sinQ <= tbl[addr];
    cosQ <= tbl[cosAddr];
  end

endmodule

// File: rtl/dds_premod_dp.sv
module dds_premod_dp
  import dds_premod_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  parameter int PHASE_W   = 32,
  parameter int LUT_AW    = 10,
  parameter int AMP_W     = 16,
  parameter int PIPE_LAT  = 13
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrlS,
  input  logic [$clog2(NUM_SLOTS)-1:0] issueSlot,
  input  logic                         cfgWe,
  input  logic                         cfgSel,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfgAddr,
  input  logic [PHASE_W-1:0]           cfgData,
  output logic                         resValid,
  output logic [$clog2(NUM_SLOTS)-1:0] resSlot,
  output logic signed [AMP_W-1:0]      resI,
  output logic signed [AMP_W-1:0]      resQ
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int FRONT  = 5;                 // read, add, offset, address, table
  localparam int DELAY  = PIPE_LAT - FRONT;  // trailing alignment stages

  logic [PHASE_W-1:0] phaseMem [NUM_SLOTS];
  logic [PHASE_W-1:0] incShd   [NUM_SLOTS];
  logic [PHASE_W-1:0] offShd   [NUM_SLOTS];
  logic [PHASE_W-1:0] incAct   [NUM_SLOTS];
  logic [PHASE_W-1:0] offAct   [NUM_SLOTS];

  // shadow tables, written from the configuration port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        incShd[k] <= '0;
        offShd[k] <= '0;
      end
    end else if (cfgWe) begin
      if (cfgSel) offShd[cfgAddr] <= cfgData;
      else        incShd[cfgAddr] <= cfgData;
    end
  end

  // working tables, refreshed when a sweep is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        incAct[k] <= '0;
        offAct[k] <= '0;
      end
    end else if (ctrlS.load) begin
      incAct <= incShd;
      offAct <= offShd;
    end
  end

  // stage 1: read phase, increment, offset
  logic               v1;
  logic [SLOT_W-1:0]  s1;
  logic [PHASE_W-1:0] ph1, inc1, off1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; s1 <= '0; ph1 <= '0; inc1 <= '0; off1 <= '0;
    end else begin
      v1   <= ctrlS.issue;
      s1   <= issueSlot;
      ph1  <= phaseMem[issueSlot];
      inc1 <= incAct[issueSlot];
      off1 <= offAct[issueSlot];
    end
  end

  // stage 2: advance and write back
  logic               v2;
  logic [SLOT_W-1:0]  s2;
  logic [PHASE_W-1:0] sum2, off2, nextPh;

  assign nextPh = ph1 + inc1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SLOTS; k++) phaseMem[k] <= '0;
      v2 <= 1'b0; s2 <= '0; sum2 <= '0; off2 <= '0;
    end else begin
      if (v1) phaseMem[s1] <= nextPh;
      v2   <= v1;
      s2   <= s1;
      sum2 <= nextPh;
      off2 <= off1;
    end
  end

  // stage 3: apply offset (not written back); stage 4: table address
  logic               v3, v4, v5;
  logic [SLOT_W-1:0]  s3, s4, s5;
  logic [PHASE_W-1:0] fin3;
  logic [LUT_AW-1:0]  addr4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v3 <= 1'b0; s3 <= '0; fin3 <= '0;
      v4 <= 1'b0; s4 <= '0; addr4 <= '0;
      v5 <= 1'b0; s5 <= '0;
    end else begin
      v3    <= v2;
      s3    <= s2;
      fin3  <= sum2 + off2;
      v4    <= v3;
      s4    <= s3;
      addr4 <= fin3[PHASE_W-1 -: LUT_AW];
      v5    <= v4;
      s5    <= s4;
    end
  end

  // stage 5: registered sine/cosine lookup
  logic signed [AMP_W-1:0] sin5, cos5;

  dds_premod_lut #(.AW(LUT_AW), .DW(AMP_W)) lut_i (
    .clk  (clk),
    .addr (addr4),
    .sinQ (sin5),
    .cosQ (cos5)
  );

  // trailing stages keep slot tag and valid aligned with the samples
  logic                    dV [DELAY];
  logic [SLOT_W-1:0]       dS [DELAY];
  logic signed [AMP_W-1:0] dI [DELAY];
  logic signed [AMP_W-1:0] dQ [DELAY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DELAY; k++) begin
        dV[k] <= 1'b0; dS[k] <= '0; dI[k] <= '0; dQ[k] <= '0;
      end
    end else begin
      dV[0] <= v5;
      dS[0] <= s5;
      dI[0] <= cos5;
      dQ[0] <= sin5;
      for (int k = 1; k < DELAY; k++) begin
        dV[k] <= dV[k-1];
        dS[k] <= dS[k-1];
        dI[k] <= dI[k-1];
        dQ[k] <= dQ[k-1];
      end
    end
  end

  assign resValid = dV[DELAY-1];
  assign resSlot  = dS[DELAY-1];
  assign resI     = dI[DELAY-1];
  assign resQ     = dQ[DELAY-1];

endmodule

// File: rtl/dds_premod.sv
module dds_premod
  import dds_premod_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int PHASE_W  = 32,
  parameter int LUT_AW   = 10,
  parameter int AMP_W    = 16,
  parameter int PIPE_LAT = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      scanStrobe,
  input  logic                      cfgWe,
  input  logic                      cfgSel,
  input  logic [$clog2(NUM_CH):0]   cfgAddr,
  input  logic [PHASE_W-1:0]        cfgData,
  output logic                      outValid,
  output logic [AMP_W-1:0]          outI,
  output logic [AMP_W-1:0]          outQ,
  output logic [$clog2(NUM_CH)-1:0] outChan,
  output logic                      outNuller,
  output logic                      outOverrun
);

  localparam int NUM_SLOTS = 2 * NUM_CH;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  ctrl_t                   ctrlS;
  logic [SLOT_W-1:0]       issueSlot;
  logic [SLOT_W-1:0]       resSlot;
  logic signed [AMP_W-1:0] resI, resQ;

  dds_premod_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .scanStrobe (scanStrobe),
    .ctrlS      (ctrlS),
    .issueSlot  (issueSlot),
    .overrun    (outOverrun)
  );

  dds_premod_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .PHASE_W   (PHASE_W),
    .LUT_AW    (LUT_AW),
    .AMP_W     (AMP_W),
    .PIPE_LAT  (PIPE_LAT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlS     (ctrlS),
    .issueSlot (issueSlot),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .resValid  (outValid),
    .resSlot   (resSlot),
    .resI      (resI),
    .resQ      (resQ)
  );

  assign outI      = resI;
  assign outQ      = resQ;
  assign outChan   = resSlot[SLOT_W-1:1];
  assign outNuller = resSlot[0];

endmodule

// File: rtl/dds_premod_chk.sv
module dds_premod_chk #(
  parameter int NUM_CH   = 128,
  parameter int PIPE_LAT = 13
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      scanStrobe,
  input logic                      issue,
  input logic                      load,
  input logic                      outValid,
  input logic [$clog2(NUM_CH)-1:0] outChan,
  input logic                      outNuller,
  input logic                      outOverrun
);

  localparam int CH_W = $clog2(NUM_CH);

  // issue history, used to judge output timing
  logic [PIPE_LAT-1:0] issueHist;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) issueHist <= '0;
    else       issueHist <= {issueHist[PIPE_LAT-2:0], issue};
  end

  // R5: each issued slot emerges exactly PIPE_LAT clocks later
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid == issueHist[PIPE_LAT-1]);

  // R1: a carrier beat is followed by the nuller of the same channel
  p_carrier_then_nuller_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outNuller && issueHist[PIPE_LAT-2]
      |=> outValid && outNuller && outChan == $past(outChan));

  // R1: after a nuller beat the next beat is the next channel's carrier
  p_chan_advance_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outNuller && outChan != CH_W'(NUM_CH - 1) && issueHist[PIPE_LAT-2]
      |=> outValid && !outNuller && outChan == $past(outChan) + CH_W'(1));

  // R7: a dropped pulse raises the overrun flag
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    scanStrobe && issue && !load |=> outOverrun);

  // R7: the overrun flag is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    outOverrun |=> outOverrun);

  // R8: an accepted pulse never raises the overrun flag
  p_no_overrun_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    load && !outOverrun |=> !outOverrun);

endmodule

bind dds_premod dds_premod_chk #(.NUM_CH(NUM_CH), .PIPE_LAT(PIPE_LAT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .scanStrobe (scanStrobe),
  .issue      (ctrlS.issue),
  .load       (ctrlS.load),
  .outValid   (outValid),
  .outChan    (outChan),
  .outNuller  (outNuller),
  .outOverrun (outOverrun)
);

// File: tb/dds_premod_tb_top.sv
module dds_premod_tb_top;

  localparam int NSL = 256;
  localparam int LAT = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanStrobe = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        outValid;
  logic [15:0] outI, outQ;
  logic [6:0]  outChan;
  logic        outNuller;
  logic        outOverrun;

  dds_premod dut_i (
    .clk(clk), .rstN(rstN), .scanStrobe(scanStrobe), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outI(outI), .outQ(outQ), .outChan(outChan),
    .outNuller(outNuller), .outOverrun(outOverrun)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  typedef struct {
    int i; int q; int chan; int nul; int cyc;
  } beat_t;
  beat_t expQ[$];

  logic [31:0] phM [NSL];
  logic [31:0] incS[NSL];
  logic [31:0] incA[NSL];
  logic [31:0] offS[NSL];
  logic [31:0] offA[NSL];

  function automatic int sinRef(input int idx);
    real v;
    v = 32767.0 * $sin(6.283185307179586 * idx / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return $rtoi(v - 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // model of one accepted sweep: R6 copy, R2 advance, R3 offset, R4 lookup
  task automatic pushScan(input int c);
    logic [31:0] fin;
    int a;
    beat_t b;
    for (int k = 0; k < NSL; k++) begin
      incA[k] = incS[k];
      offA[k] = offS[k];
    end
    for (int k = 0; k < NSL; k++) begin
      phM[k] = phM[k] + incA[k];
      fin    = phM[k] + offA[k];
      a      = int'(fin[31:22]);
      b.i    = sinRef((a + 256) % 1024);
      b.q    = sinRef(a);
      b.chan = k >> 1;
      b.nul  = k & 1;
      b.cyc  = c + 1 + LAT + k;
      expQ.push_back(b);
    end
  endtask

  task automatic cfgWrite(input bit sel, input int slot, input logic [31:0] d);
    @(negedge clk);
    cfgWe   = 1'b1;
    cfgSel  = sel;
    cfgAddr = 8'(slot);
    cfgData = d;
    if (sel) offS[slot] = d;
    else     incS[slot] = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // pulse the scan input at the negedge where cyc == target
  task automatic strobeAt(input int target, input bit accepted);
    while (cyc < target) @(negedge clk);
    scanStrobe = 1'b1;
    if (accepted) pushScan(cyc);
    @(negedge clk);
    scanStrobe = 1'b0;
  endtask

  task automatic startScan(output int c);
    @(negedge clk);
    c = cyc;
    strobeAt(c, 1'b1);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        beat_t b;
        b = expQ.pop_front();
        check(outValid == 1'b1, "R5", "beat timing", int'(outValid), 1);
        if (outValid) begin
          check(int'(outChan) == b.chan, "R1", "channel", int'(outChan), b.chan);
          check(int'(outNuller) == b.nul, "R1", "nuller bit", int'(outNuller), b.nul);
          check(int'($signed(outI)) == b.i, "R4", "I sample", int'($signed(outI)), b.i);
          check(int'($signed(outQ)) == b.q, "R4", "Q sample", int'($signed(outQ)), b.q);
        end
      end else if (outValid) begin
        check(1'b0, "R7", "unexpected beat", 1, 0);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    for (int k = 0; k < NSL; k++) begin
      phM[k] = '0; incS[k] = '0; incA[k] = '0; offS[k] = '0; offA[k] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 1'b0, "R9", "valid in reset", int'(outValid), 0);
    check(outOverrun == 1'b0, "R9", "overrun in reset", int'(outOverrun), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep with all tables zero: I = 32767, Q = 0 (R4, R9)
    startScan(c);
    drain();

    // distinct increments and offsets per slot (R2, R3, R6)
    for (int k = 0; k < NSL; k++) begin
      cfgWrite(1'b0, k, 32'(k) * 32'h0123_4567 + 32'h0040_0000);
      cfgWrite(1'b1, k, 32'(k) * 32'h0093_0000);
    end
    cfgWrite(1'b0, 3, 32'h0);            // R3: offset-only slot, steady output
    cfgWrite(1'b1, 3, 32'h4000_0000);

    // two sweeps; mid-sweep write (R6); pulse in last issue cycle chains (R8)
    startScan(c);
    repeat (50) @(negedge clk);
    cfgWrite(1'b0, 10, 32'h4000_0000);
    strobeAt(c + 256, 1'b1);
    drain();
    check(outOverrun == 1'b0, "R8", "overrun after chained sweep", int'(outOverrun), 0);

    // dropped pulses mid-sweep and one cycle before the last issue (R7)
    startScan(c);
    strobeAt(c + 100, 1'b0);
    @(negedge clk);
    check(outOverrun == 1'b1, "R7", "overrun after dropped pulse", int'(outOverrun), 1);
    strobeAt(c + 255, 1'b0);
    drain();
    check(outOverrun == 1'b1, "R7", "overrun sticky", int'(outOverrun), 1);

    // another sweep: phases keep advancing (R2), flag stays set (R7)
    startScan(c);
    drain();
    check(outOverrun == 1'b1, "R7", "overrun sticky after sweep", int'(outOverrun), 1);
    check(expQ.size() == 0, "R1", "beats left over", expQ.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule